// File: doc/BRIEF.md
# Translation Cache Flush Dispatcher

This block sits beside the per-core instruction and data translation caches. A maintenance write, made of an operation code, a 32-bit value and the number of the core that issued it, is turned into flush requests. Shareable and plain forms of the four flush kinds go to both caches of every core at once. The instruction-only and data-only forms go to one cache of the issuing core. The flush kinds are: everything, one page within one address-space ID, one address-space ID, and one page across all IDs.

The page and the ID are taken from the written value and presented with the kind on shared operand outputs. Each targeted cache holds its request bit until it acknowledges. When the last outstanding acknowledge has been taken, the block gives a one-cycle completion pulse and is ready for the next write. A write that arrives while a flush is outstanding is dropped, and the `busy` output shows when that applies.

Top module: `tlbm_dispatch`

## Requirements
- R1: After reset `busy`, `done` and every request bit are 0. Whenever `busy` is 0, no request bit is set.
- R2: `flush_page` equals `op_value` with bits 11:0 cleared when the kind is page-plus-ID (1) or page-only (3). For the other kinds it is 0.
- R3: `flush_asid` equals `op_value[7:0]` when the kind is page-plus-ID (1) or ID-only (2). For the other kinds it is 0.
- R4: Codes 0 to 7 are broadcast. In the cycle after acceptance, every bit of `itlb_req` and of `dtlb_req` is 1.
- R5: Codes 8, 10 and 12 set only `itlb_req[op_core]`. Codes 9, 11 and 13 set only `dtlb_req[op_core]`. Both appear in the cycle after acceptance.
- R6: `flush_kind` is `op_code[2:1]`, coded 0 all, 1 page plus ID, 2 ID only, 3 page only. Codes 0,1,8,9 flush all. Codes 2,3,10,11 flush by page plus ID. Codes 4,5,12,13 flush by ID. Codes 6,7 flush by page across IDs.
- R7: A request bit stays 1 until its own acknowledge is sampled, and drops in the next cycle. An acknowledge on a bit that is not requested has no effect.
- R8: `done` is a one-cycle pulse in the cycle after the last outstanding acknowledge is sampled. In that cycle `busy` is 0 and all request bits are 0.
- R9: While `busy` is 1, `op_valid` is ignored. The requests, kind and operands stay unchanged.
- R10: Codes 14 and 15 are ignored. They raise no request, no `busy` and no `done`.
- R11: A write presented in the cycle in which `done` is 1 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Maintenance write present |
| op_code | input | 4 | Operation code |
| op_value | input | 32 | Written value carrying page and ID |
| op_core | input | CORE_W | Issuing core |
| busy | output | 1 | A flush is outstanding |
| itlb_req | output | NUM_CORES | Instruction cache flush request per core |
| dtlb_req | output | NUM_CORES | Data cache flush request per core |
| flush_kind | output | 2 | Flush kind |
| flush_page | output | 32 | Page address operand |
| flush_asid | output | 8 | Address-space ID operand |
| itlb_ack | input | NUM_CORES | Instruction cache acknowledge per core |
| dtlb_ack | input | NUM_CORES | Data cache acknowledge per core |
| done | output | 1 | Completion pulse |

## Verification
Two events can fall in the same cycle: the completion of one flush and the arrival of the next write. The bench also holds `op_valid` high during the outstanding phase and into the `done` cycle, so that a write is present both while busy and at completion. It sends acknowledges for several cores in one cycle, spreads others over several cycles, and adds acknowledges on bits that are not requested. A behavioural model, updated on every clock edge, decides which of the competing writes is dropped and which is accepted. The outputs are compared against this model on every clock.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

    typedef enum logic [1:0] {
        FK_ALL       = 2'd0,
        FK_PAGE_ASID = 2'd1,
        FK_ASID      = 2'd2,
        FK_PAGE      = 2'd3
    } flush_kind_e;

    typedef struct packed {
        logic        legal;
        logic        bcast;
        logic        iside;
        logic        dside;
        flush_kind_e kind;
    } op_dec_t;

    localparam int unsigned OP_W        = 4;
    localparam int unsigned LOCAL_FIRST = 8;
    localparam int unsigned LOCAL_LAST  = 13;

    function automatic op_dec_t decode_op(input logic [OP_W-1:0] code);
        op_dec_t r;
        r.kind  = flush_kind_e'(code[2:1]);
        r.bcast = (code < OP_W'(LOCAL_FIRST));
        r.legal = (code <= OP_W'(LOCAL_LAST));
        r.iside = r.legal && (r.bcast || !code[0]);
        r.dside = r.legal && (r.bcast || code[0]);
        return r;
    endfunction

    function automatic logic kind_has_page(input flush_kind_e k);
        return (k == FK_PAGE_ASID) || (k == FK_PAGE);
    endfunction

    function automatic logic kind_has_asid(input flush_kind_e k);
        return (k == FK_PAGE_ASID) || (k == FK_ASID);
    endfunction

endpackage

// File: rtl/tlbm_decode.sv
module tlbm_decode
    import tlbm_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output op_dec_t         dec
);
    always_comb begin
        dec = decode_op(op_code);
    end
endmodule

// File: rtl/tlbm_target.sv
module tlbm_target
    import tlbm_pkg::*;
#(
    parameter int unsigned NUM_CORES = 4,
    localparam int unsigned CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  op_dec_t              dec,
    input  logic [CORE_W-1:0]    core,
    output logic [NUM_CORES-1:0] ivec,
    output logic [NUM_CORES-1:0] dvec
);
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic hit;
        always_comb begin
            hit     = dec.bcast || (core == CORE_W'(c));
            ivec[c] = dec.iside && hit;
            dvec[c] = dec.dside && hit;
        end
    end
endmodule

// File: rtl/tlbm_operand.sv
module tlbm_operand
    import tlbm_pkg::*;
#(
    parameter int unsigned VALUE_W  = 32,
    parameter int unsigned PAGE_LSB = 12,
    parameter int unsigned ASID_W   = 8
) (
    input  flush_kind_e        kind,
    input  logic [VALUE_W-1:0] value,
    output logic [VALUE_W-1:0] page,
    output logic [ASID_W-1:0]  asid
);
    localparam logic [VALUE_W-1:0] PAGE_MASK = ~((VALUE_W'(1) << PAGE_LSB) - VALUE_W'(1));

    always_comb begin
        page = kind_has_page(kind) ? (value & PAGE_MASK) : '0;
        asid = kind_has_asid(kind) ? value[ASID_W-1:0] : '0;
    end
endmodule

// File: rtl/tlbm_dispatch.sv
module tlbm_dispatch
    import tlbm_pkg::*;
#(
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned VALUE_W   = 32,
    parameter int unsigned PAGE_LSB  = 12,
    parameter int unsigned ASID_W    = 8,
    localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [OP_W-1:0]      op_code,
    input  logic [VALUE_W-1:0]   op_value,
    input  logic [CORE_W-1:0]    op_core,
    output logic                 busy,
    output logic [NUM_CORES-1:0] itlb_req,
    output logic [NUM_CORES-1:0] dtlb_req,
    output logic [1:0]           flush_kind,
    output logic [VALUE_W-1:0]   flush_page,
    output logic [ASID_W-1:0]    flush_asid,
    input  logic [NUM_CORES-1:0] itlb_ack,
    input  logic [NUM_CORES-1:0] dtlb_ack,
    output logic                 done
);
    typedef struct packed {
        logic                 busy;
        logic [NUM_CORES-1:0] ireq;
        logic [NUM_CORES-1:0] dreq;
        flush_kind_e          kind;
        logic [VALUE_W-1:0]   page;
        logic [ASID_W-1:0]    asid;
        logic                 done;
    } state_t;

    op_dec_t              dec;
    logic [NUM_CORES-1:0] tgt_i, tgt_d;
    logic [VALUE_W-1:0]   opnd_page;
    logic [ASID_W-1:0]    opnd_asid;
    logic [NUM_CORES-1:0] pend_i, pend_d;
    state_t               st_d, st_q;

    tlbm_decode u_decode (
        .op_code (op_code),
        .dec     (dec)
    );

    tlbm_target #(.NUM_CORES(NUM_CORES)) u_target (
        .dec  (dec),
        .core (op_core),
        .ivec (tgt_i),
        .dvec (tgt_d)
    );

    tlbm_operand #(
        .VALUE_W  (VALUE_W),
        .PAGE_LSB (PAGE_LSB),
        .ASID_W   (ASID_W)
    ) u_operand (
        .kind  (dec.kind),
        .value (op_value),
        .page  (opnd_page),
        .asid  (opnd_asid)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        pend_i    = st_q.ireq & ~itlb_ack;
        pend_d    = st_q.dreq & ~dtlb_ack;
        if (st_q.busy) begin
            st_d.ireq = pend_i;
            st_d.dreq = pend_d;
            if ((pend_i == '0) && (pend_d == '0)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (op_valid && dec.legal) begin
            st_d.busy = 1'b1;
            st_d.ireq = tgt_i;
            st_d.dreq = tgt_d;
            st_d.kind = dec.kind;
            st_d.page = opnd_page;
            st_d.asid = opnd_asid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = st_q.busy;
    assign itlb_req   = st_q.ireq;
    assign dtlb_req   = st_q.dreq;
    assign flush_kind = st_q.kind;
    assign flush_page = st_q.page;
    assign flush_asid = st_q.asid;
    assign done       = st_q.done;

endmodule

// File: rtl/tlbm_dispatch_chk.sv
module tlbm_dispatch_chk #(
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned VALUE_W   = 32,
    parameter int unsigned PAGE_LSB  = 12,
    parameter int unsigned ASID_W    = 8,
    localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 op_valid,
    input logic [3:0]           op_code,
    input logic                 busy,
    input logic [NUM_CORES-1:0] itlb_req,
    input logic [NUM_CORES-1:0] dtlb_req,
    input logic [1:0]           flush_kind,
    input logic [VALUE_W-1:0]   flush_page,
    input logic [NUM_CORES-1:0] itlb_ack,
    input logic [NUM_CORES-1:0] dtlb_ack,
    input logic                 done
);
    p_idle_noreq_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (itlb_req == '0 && dtlb_req == '0));

    p_page_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flush_page[PAGE_LSB-1:0] == '0);

    p_bcast_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_valid && op_code < 4'd8) |=> (&itlb_req && &dtlb_req));

    p_local_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_valid && op_code >= 4'd8 && op_code <= 4'd13)
        |=> ($countones({itlb_req, dtlb_req}) <= 1));

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (((itlb_req & $past(itlb_req & ~itlb_ack)) == $past(itlb_req & ~itlb_ack))
               && ((dtlb_req & $past(dtlb_req & ~dtlb_ack)) == $past(dtlb_req & ~dtlb_ack))));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && itlb_req == '0 && dtlb_req == '0));

    p_kind_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_valid) |=> $stable(flush_kind));

    p_undef_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_code >= 4'd14) |=> !busy);
endmodule

bind tlbm_dispatch tlbm_dispatch_chk #(
    .NUM_CORES (NUM_CORES),
    .VALUE_W   (VALUE_W),
    .PAGE_LSB  (PAGE_LSB),
    .ASID_W    (ASID_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .busy       (busy),
    .itlb_req   (itlb_req),
    .dtlb_req   (dtlb_req),
    .flush_kind (flush_kind),
    .flush_page (flush_page),
    .itlb_ack   (itlb_ack),
    .dtlb_ack   (dtlb_ack),
    .done       (done)
);

// File: tb/tlbm_dispatch_tb_top.sv
module tlbm_dispatch_tb_top;
    localparam int N  = 4;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [3:0]    op_code = '0;
    logic [31:0]   op_value = '0;
    logic [CW-1:0] op_core = '0;
    logic          busy, done;
    logic [N-1:0]  itlb_req, dtlb_req;
    logic [N-1:0]  itlb_ack = '0;
    logic [N-1:0]  dtlb_ack = '0;
    logic [1:0]    flush_kind;
    logic [31:0]   flush_page;
    logic [7:0]    flush_asid;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    tlbm_dispatch #(.NUM_CORES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_value(op_value), .op_core(op_core), .busy(busy),
        .itlb_req(itlb_req), .dtlb_req(dtlb_req), .flush_kind(flush_kind),
        .flush_page(flush_page), .flush_asid(flush_asid),
        .itlb_ack(itlb_ack), .dtlb_ack(dtlb_ack), .done(done)
    );

    // behavioural reference model
    bit          m_busy, m_done;
    bit [N-1:0]  m_i, m_d;
    int          m_kind;
    bit [31:0]   m_page;
    bit [7:0]    m_asid;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_i = '0; m_d = '0;
            m_kind = 0; m_page = '0; m_asid = '0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_i = m_i & ~itlb_ack;
                m_d = m_d & ~dtlb_ack;
                if (m_i == '0 && m_d == '0) begin
                    m_busy = 0;
                    m_done = 1;
                end
            end else if (op_valid && op_code <= 13) begin
                int code;
                code   = int'(op_code);
                m_busy = 1;
                if (code < 8) begin
                    m_i = '1; m_d = '1;
                    m_kind = code / 2;
                end else begin
                    m_i = '0; m_d = '0;
                    if (code % 2 == 0) m_i[op_core] = 1'b1;
                    else               m_d[op_core] = 1'b1;
                    m_kind = (code - 8) / 2;
                end
                m_page = (m_kind == 1 || m_kind == 3) ? {op_value[31:12], 12'h000} : 32'h0;
                m_asid = (m_kind == 1 || m_kind == 2) ? op_value[7:0] : 8'h0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == m_busy, "R9 busy", 64'(busy), 64'(m_busy));
            check(itlb_req == m_i, "R4/R5/R7 itlb_req", 64'(itlb_req), 64'(m_i));
            check(dtlb_req == m_d, "R4/R5/R7 dtlb_req", 64'(dtlb_req), 64'(m_d));
            check(int'(flush_kind) == m_kind, "R6 kind", 64'(flush_kind), 64'(m_kind));
            check(flush_page == m_page, "R2 page", 64'(flush_page), 64'(m_page));
            check(flush_asid == m_asid, "R3 asid", 64'(flush_asid), 64'(m_asid));
            check(done == m_done, "R8 done", 64'(done), 64'(m_done));
        end
    end

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic issue(input logic [3:0] code, input logic [31:0] val, input logic [CW-1:0] core);
        op_valid = 1'b1; op_code = code; op_value = val; op_core = core;
        tick();
        op_valid = 1'b0;
    endtask

    task automatic ack_all_until_done();
        for (int k = 0; k < 20 && !done; k++) begin
            itlb_ack = itlb_req; dtlb_ack = dtlb_req;
            tick();
        end
        itlb_ack = '0; dtlb_ack = '0;
    endtask

    task automatic run();
        tick(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check(!busy && !done && itlb_req == 0 && dtlb_req == 0, "R1 reset", 64'({busy, done, itlb_req, dtlb_req}), 64'h0);

        // R4 broadcast flush-all, all acks at once
        issue(4'd0, 32'h1234_5678, 2'd1);
        check(&itlb_req && &dtlb_req, "R4 bcast", 64'({itlb_req, dtlb_req}), 64'hFF);
        ack_all_until_done();
        check(done == 1'b1, "R8 done after acks", 64'(done), 64'h1);

        // R2 R3 R6 page+ID shareable, staggered acks, spurious acks, R9 write while busy
        issue(4'd3, 32'hDEAD_BEEF, 2'd0);
        check(flush_page == 32'hDEAD_B000 && flush_asid == 8'hEF && flush_kind == 2'd1,
              "R2 R3 R6 page+id", 64'({flush_kind, flush_page, flush_asid}), 64'({2'd1, 32'hDEAD_B000, 8'hEF}));
        op_valid = 1'b1; op_code = 4'd8; op_value = 32'hFFFF_FFFF; op_core = 2'd2;
        itlb_ack = 4'b0011; tick();
        itlb_ack = 4'b1100; dtlb_ack = 4'b0001; tick();
        check(itlb_req == 4'b0000 && dtlb_req == 4'b1110, "R7 partial ack", 64'({itlb_req, dtlb_req}), 64'h0E);
        itlb_ack = 4'b1111; dtlb_ack = 4'b0110; tick();
        check(dtlb_req == 4'b1000 && flush_asid == 8'hEF, "R9 R7 hold", 64'({dtlb_req, flush_asid}), 64'h8EF);
        itlb_ack = '0; dtlb_ack = 4'b1000; tick();
        dtlb_ack = '0;
        // done high now with op_valid still set: R11 acceptance
        check(done == 1'b1, "R8 done", 64'(done), 64'h1);
        tick();
        op_valid = 1'b0;
        check(busy && itlb_req == 4'b0100 && dtlb_req == 0, "R11 accept at done", 64'({busy, itlb_req, dtlb_req}), 64'h140);
        ack_all_until_done();

        // R3 R6 ID only, R2 page zero
        issue(4'd5, 32'hCAFE_F00D, 2'd3);
        check(flush_kind == 2'd2 && flush_page == 0 && flush_asid == 8'h0D, "R3 id only", 64'({flush_kind, flush_page, flush_asid}), 64'({2'd2, 32'h0, 8'h0D}));
        ack_all_until_done();

        // R2 R6 page across IDs
        issue(4'd6, 32'h0000_3FFF, 2'd0);
        check(flush_kind == 2'd3 && flush_page == 32'h0000_3000 && flush_asid == 0, "R2 page only", 64'({flush_kind, flush_page, flush_asid}), 64'({2'd3, 32'h3000, 8'h0}));
        ack_all_until_done();

        // R5 local forms
        issue(4'd11, 32'h8765_4321, 2'd1);
        check(itlb_req == 0 && dtlb_req == 4'b0010, "R5 d-only", 64'({itlb_req, dtlb_req}), 64'h02);
        ack_all_until_done();
        issue(4'd12, 32'h0000_00AA, 2'd3);
        check(itlb_req == 4'b1000 && dtlb_req == 0 && flush_kind == 2'd2, "R5 i-only", 64'({itlb_req, dtlb_req}), 64'h80);
        ack_all_until_done();
        issue(4'd9, 32'h0, 2'd0);
        check(dtlb_req == 4'b0001 && flush_kind == 2'd0, "R5 R6 d-all", 64'({flush_kind, dtlb_req}), 64'h01);
        ack_all_until_done();

        // R10 undefined codes
        issue(4'd14, 32'hFFFF_FFFF, 2'd0);
        check(!busy && itlb_req == 0 && dtlb_req == 0, "R10 code14", 64'({busy, itlb_req, dtlb_req}), 64'h0);
        issue(4'd15, 32'hFFFF_FFFF, 2'd0);
        tick();
        check(!busy && !done, "R10 code15", 64'({busy, done}), 64'h0);
        tick(2);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (100000) @(posedge clk);
                tests++; fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule